// File: doc/BRIEF.md
# Fast Ethernet Receive Symbol Decoder

The block rebuilds receive nibbles from a three-level serial line code, taking one symbol per bit clock. Each bit clock, a line level that differs from the previous one becomes a 1 and an unchanged level becomes a 0. These bits are then descrambled by a self-synchronising 11-stage key generator, which locks onto the all-ones idle stream. The descrambled bits are cut into 5-bit code groups, aligned on the start-of-stream delimiter pair, and translated back to 4-bit data.

Two mode inputs pick the data path. In standard mode every stage is used. Symbol mode delivers the aligned 5-bit group without translation. Scrambler-bypass mode feeds the line-decoded bits straight to alignment and translation. A frame starts on the delimiter and ends on the end-of-stream group. A group outside the data table, seen during a frame, flags an error for that nibble only. A direct jump between the two non-zero levels is a coding violation and sets a sticky flag.

Top module: `rxpcs_top`

## Requirements
- R1: After reset, `rxd`, `rx_dv`, `rx_er` and `code_viol` are all 0.
- R2: A line bit is 1 when `line_sym` differs from the symbol of the previous bit clock and 0 when it is equal. Levels are encoded 2'b00 = 0, 2'b01 = +1, 2'b11 = -1.
- R3: A symbol of 2'b10, or a step directly from +1 to -1 or from -1 to +1, sets `code_viol` on the next edge. `code_viol` then stays 1 until reset.
- R4: In standard and symbol mode, frames are hunted only after descrambler lock. Lock is declared after 30 consecutive descrambled 1s. A delimiter seen before lock is ignored, and `rx_dv` stays 0.
- R5: The frame starts on the 10-bit pattern 1100010001, with the leftmost bit received first. `rx_dv` goes to 1 with the first data group after the pattern.
- R6: In standard mode each group is translated to a nibble on `rxd[3:0]`, with `rxd[4]` = 0. The translation is 0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101, with the leftmost bit received first and D0 the LSB of the nibble.
- R7: In standard mode, a group inside a frame that is not in the R6 table sets `rx_er` for that nibble period only. `rx_dv` stays 1 during that period.
- R8: The group 01101 (or 00111) ends the frame: `rx_dv`, `rx_er` and `rxd` become 0.
- R9: In symbol mode `rxd` carries the raw group with the first-received bit in `rxd[4]`, and `rx_er` stays 0.
- R10: In scrambler-bypass mode the line-decoded bits go directly to alignment and translation, with no lock required.
- R11: `rxd`, `rx_dv` and `rx_er` change only on the edge that takes in the fifth bit of a group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sym | input | 2 | Line level this bit clock (00 = 0, 01 = +1, 11 = -1) |
| sym_mode | input | 1 | 1: deliver raw 5-bit groups |
| scr_bypass | input | 1 | 1: skip the descrambler |
| rxd | output | 5 | Nibble in [3:0], or raw group in symbol mode |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error for the current nibble |
| code_viol | output | 1 | Sticky line coding violation |

## Verification
The result of a group is due on the same edge that samples the fifth bit of that group, with no further pipeline delay. The bench therefore checks 1 ns after that edge, once the last bit has been driven. A coding violation shows on the edge that samples the offending symbol, and the bench checks it just after that edge. Mid-group samples confirm that the outputs hold between group edges.

// File: rtl/rxpcs_pkg.sv
package rxpcs_pkg;
  localparam int GRP_W = 5;
  localparam int NIB_W = 4;
  localparam logic [1:0] LVL_ZERO = 2'b00;
  localparam logic [1:0] LVL_POS  = 2'b01;
  localparam logic [1:0] LVL_NEG  = 2'b11;
  localparam logic [GRP_W-1:0] CG_END  = 5'b01101;
  localparam logic [GRP_W-1:0] CG_RST  = 5'b00111;
  localparam logic [2*GRP_W-1:0] DELIM = 10'b1100010001;

  typedef struct packed {
    logic             ok;
    logic [NIB_W-1:0] nib;
  } dec_t;

  // group bit 4 is the first received bit
  function automatic dec_t grp_to_nib(input logic [GRP_W-1:0] g);
    dec_t r;
    r.ok = 1'b1;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default: begin r.ok = 1'b0; r.nib = 4'h0; end
    endcase
    return r;
  endfunction

  function automatic logic is_jump(input logic [1:0] prev, input logic [1:0] cur);
    return ((prev == LVL_POS) && (cur == LVL_NEG)) ||
           ((prev == LVL_NEG) && (cur == LVL_POS)) ||
           (cur == 2'b10);
  endfunction
endpackage

// File: rtl/mlt3_rx_dec.sv
module mlt3_rx_dec
  import rxpcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] line_sym,
  output logic       bit_o,
  output logic [1:0] prev_lvl,
  output logic       jump_evt,
  output logic       viol
);
  always_comb begin
    bit_o    = (line_sym != prev_lvl);
    jump_evt = is_jump(prev_lvl, line_sym);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_lvl <= LVL_ZERO;
      viol     <= 1'b0;
    end else begin
      prev_lvl <= line_sym;
      if (jump_evt) viol <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_descrambler.sv
module rx_descrambler #(
  parameter int LFSR_W    = 11,
  parameter int TAP_IDX   = 8,
  parameter int LOCK_ONES = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_i,
  input  logic bypass,
  output logic plain_o,
  output logic locked_o
);
  localparam int CNT_W = $clog2(LOCK_ONES + 1);

  logic [LFSR_W-1:0] lfsr;
  logic [CNT_W-1:0]  ones_cnt;
  logic              key;
  logic              dscr;

  always_comb begin
    key     = lfsr[LFSR_W-1] ^ lfsr[TAP_IDX];
    dscr    = bit_i ^ key;
    plain_o = bypass ? bit_i : dscr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr     <= '0;
      ones_cnt <= '0;
      locked_o <= 1'b0;
    end else begin
      // before lock assume the plain stream is all ones (idle)
      lfsr <= {lfsr[LFSR_W-2:0], locked_o ? key : ~bit_i};
      if (!locked_o) begin
        if (dscr) begin
          if (ones_cnt == CNT_W'(LOCK_ONES - 1)) locked_o <= 1'b1;
          ones_cnt <= ones_cnt + 1'b1;
        end else begin
          ones_cnt <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rx_group_dec.sv
module rx_group_dec
  import rxpcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_i,
  input  logic             hunt_en,
  input  logic             sym_mode,
  output logic [GRP_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             grp_done,
  output logic             delim_hit,
  output logic             in_frame
);
  localparam int SR_W  = 2 * GRP_W;
  localparam int CNT_W = $clog2(GRP_W);

  logic [SR_W-1:0]  sr;
  logic [SR_W-1:0]  sr_next;
  logic [CNT_W-1:0] cnt;
  logic [GRP_W-1:0] cg;
  dec_t             dec;
  logic             is_end;

  always_comb begin
    sr_next   = {sr[SR_W-2:0], bit_i};
    cg        = sr_next[GRP_W-1:0];
    dec       = grp_to_nib(cg);
    is_end    = (cg == CG_END) || (cg == CG_RST);
    delim_hit = hunt_en && !in_frame && (sr_next == DELIM);
    grp_done  = in_frame && (cnt == CNT_W'(GRP_W - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      in_frame <= 1'b0;
      rxd      <= '0;
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
    end else begin
      sr <= sr_next;
      if (delim_hit) begin
        in_frame <= 1'b1;
        cnt      <= '0;
      end else if (grp_done) begin
        cnt <= '0;
        if (is_end) begin
          in_frame <= 1'b0;
          rx_dv    <= 1'b0;
          rx_er    <= 1'b0;
          rxd      <= '0;
        end else begin
          rx_dv <= 1'b1;
          if (sym_mode) begin
            rxd   <= cg;
            rx_er <= 1'b0;
          end else begin
            rxd   <= {1'b0, dec.nib};
            rx_er <= !dec.ok;
          end
        end
      end else if (in_frame) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxpcs_top.sv
module rxpcs_top
  import rxpcs_pkg::*;
#(
  parameter int LFSR_W    = 11,
  parameter int TAP_IDX   = 8,
  parameter int LOCK_ONES = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       line_sym,
  input  logic             sym_mode,
  input  logic             scr_bypass,
  output logic [GRP_W-1:0] rxd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic             code_viol
);
  logic       line_bit;
  logic [1:0] prev_lvl;
  logic       jump_evt;
  logic       plain_bit;
  logic       locked;
  logic       hunt_en;
  logic       grp_done;
  logic       delim_hit;
  logic       in_frame;

  mlt3_rx_dec u_mlt (
    .clk(clk), .rst(rst), .line_sym(line_sym),
    .bit_o(line_bit), .prev_lvl(prev_lvl), .jump_evt(jump_evt), .viol(code_viol)
  );

  rx_descrambler #(.LFSR_W(LFSR_W), .TAP_IDX(TAP_IDX), .LOCK_ONES(LOCK_ONES)) u_dscr (
    .clk(clk), .rst(rst), .bit_i(line_bit), .bypass(scr_bypass),
    .plain_o(plain_bit), .locked_o(locked)
  );

  assign hunt_en = locked || scr_bypass;

  rx_group_dec u_grp (
    .clk(clk), .rst(rst), .bit_i(plain_bit), .hunt_en(hunt_en), .sym_mode(sym_mode),
    .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .grp_done(grp_done), .delim_hit(delim_hit), .in_frame(in_frame)
  );
endmodule

// File: rtl/rxpcs_chk.sv
module rxpcs_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] line_sym,
  input logic [1:0] prev_lvl,
  input logic [4:0] rxd,
  input logic       rx_dv,
  input logic       rx_er,
  input logic       code_viol,
  input logic       grp_done,
  input logic       locked
);
  // R3
  viol_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    code_viol |=> code_viol);

  // R3
  viol_on_jump_chk: assert property (@(posedge clk) disable iff (rst)
    ((prev_lvl == 2'b01 && line_sym == 2'b11) ||
     (prev_lvl == 2'b11 && line_sym == 2'b01) || line_sym == 2'b10) |=> code_viol);

  // R7
  er_within_dv_chk: assert property (@(posedge clk) disable iff (rst)
    rx_er |-> rx_dv);

  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_done |=> $stable({rxd, rx_dv, rx_er}));

  // R4
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);
endmodule

bind rxpcs_top rxpcs_chk u_chk (
  .clk(clk), .rst(rst), .line_sym(line_sym), .prev_lvl(prev_lvl),
  .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er), .code_viol(code_viol),
  .grp_done(grp_done), .locked(locked)
);

// File: tb/test_rxpcs_top.sv
module test_rxpcs_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] line_sym = 2'b00;
  logic       sym_mode = 1'b0;
  logic       scr_bypass = 1'b0;
  logic [4:0] rxd;
  logic       rx_dv, rx_er, code_viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int lvl_idx = 0;
  bit scr_on = 1'b0;
  bit kq[$];
  logic [4:0] enc [16];

  always #2 clk = ~clk;

  rxpcs_top i_rxpcs_top (
    .clk(clk), .rst(rst), .line_sym(line_sym), .sym_mode(sym_mode),
    .scr_bypass(scr_bypass), .rxd(rxd), .rx_dv(rx_dv), .rx_er(rx_er),
    .code_viol(code_viol)
  );

  function automatic logic [1:0] lvl_code(input int i);
    case (i)
      1: return 2'b01;
      3: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  // key stream k[n] = k[n-11] xor k[n-9]
  function automatic bit next_key();
    bit k;
    int n;
    n = kq.size();
    k = kq[n-11] ^ kq[n-9];
    kq.push_back(k);
    return k;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit p);
    bit s;
    s = p;
    if (scr_on) s = p ^ next_key();
    if (s) lvl_idx = (lvl_idx + 1) % 4;
    @(negedge clk) line_sym = lvl_code(lvl_idx);
    @(posedge clk);
  endtask

  task automatic send_cg(input logic [4:0] c);
    for (int i = 4; i >= 0; i--) send_bit(c[i]);
    #1;
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_cg(5'b11111);
  endtask

  task automatic send_delim();
    send_cg(5'b11000);
    send_cg(5'b10001);
  endtask

  task automatic do_reset(input bit byp, input bit sym);
    @(negedge clk);
    rst = 1'b1; scr_bypass = byp; sym_mode = sym; line_sym = 2'b00; lvl_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    enc[0] = 5'b11110; enc[1] = 5'b01001; enc[2] = 5'b10100; enc[3] = 5'b10101;
    enc[4] = 5'b01010; enc[5] = 5'b01011; enc[6] = 5'b01110; enc[7] = 5'b01111;
    enc[8] = 5'b10010; enc[9] = 5'b10011; enc[10] = 5'b10110; enc[11] = 5'b10111;
    enc[12] = 5'b11010; enc[13] = 5'b11011; enc[14] = 5'b11100; enc[15] = 5'b11101;
    for (int i = 0; i < 11; i++) kq.push_back(bit'((11'h5A3 >> i) & 1));

    // R1 reset state
    do_reset(1'b0, 1'b0);
    #1;
    check("R1 rxd", 32'(rxd), 0);
    check("R1 rx_dv", 32'(rx_dv), 0);
    check("R1 rx_er", 32'(rx_er), 0);
    check("R1 code_viol", 32'(code_viol), 0);

    // R4 delimiter before lock is ignored
    scr_on = 1'b1;
    send_idle(2);
    send_delim();
    send_cg(enc[5]);
    check("R4 dv before lock", 32'(rx_dv), 0);

    // R2 R5 R6 standard mode, all nibbles
    send_idle(12);
    send_delim();
    for (int n = 0; n < 16; n++) begin
      send_cg(enc[n]);
      check("R6 nibble", 32'(rxd), 32'(n));
      check("R5 rx_dv", 32'(rx_dv), 1);
      check("R6 rx_er", 32'(rx_er), 0);
    end
    // R11 hold mid-group, then R7 invalid group 00000
    send_bit(1'b0); send_bit(1'b0); #1;
    check("R11 rxd hold", 32'(rxd), 32'hF);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); #1;
    check("R7 rx_er set", 32'(rx_er), 1);
    check("R7 rx_dv kept", 32'(rx_dv), 1);
    send_cg(enc[5]);
    check("R7 rx_er one nibble", 32'(rx_er), 0);
    check("R6 after error", 32'(rxd), 5);
    send_cg(5'b01101);
    check("R8 dv low", 32'(rx_dv), 0);
    check("R8 rxd zero", 32'(rxd), 0);
    send_cg(5'b00111);
    send_idle(4);

    // R9 symbol mode
    sym_mode = 1'b1;
    send_idle(2);
    send_delim();
    for (int n = 0; n < 16; n++) begin
      send_cg(enc[n]);
      check("R9 raw group", 32'(rxd), 32'(enc[n]));
      check("R9 rx_dv", 32'(rx_dv), 1);
    end
    send_cg(5'b00000);
    check("R9 no rx_er", 32'(rx_er), 0);
    send_cg(5'b01101);
    check("R8 dv low sym", 32'(rx_dv), 0);
    send_cg(5'b00111);

    // R10 scrambler bypass
    scr_on = 1'b0;
    do_reset(1'b1, 1'b0);
    send_idle(2);
    send_delim();
    for (int n = 0; n < 16; n++) begin
      send_cg(enc[n]);
      check("R10 nibble", 32'(rxd), 32'(n));
      check("R10 rx_dv", 32'(rx_dv), 1);
    end
    send_cg(5'b01101);
    check("R10 end", 32'(rx_dv), 0);

    // R3 coding violations
    check("R3 no false viol", 32'(code_viol), 0);
    do_reset(1'b0, 1'b0);
    @(negedge clk) line_sym = 2'b01;
    @(negedge clk) line_sym = 2'b11;
    @(posedge clk); #1;
    check("R3 jump pos to neg", 32'(code_viol), 1);
    @(negedge clk) line_sym = 2'b00;
    repeat (3) @(posedge clk);
    #1;
    check("R3 sticky", 32'(code_viol), 1);
    do_reset(1'b0, 1'b0);
    @(negedge clk) line_sym = 2'b11;
    @(negedge clk) line_sym = 2'b01;
    @(posedge clk); #1;
    check("R3 jump neg to pos", 32'(code_viol), 1);
    do_reset(1'b0, 1'b0);
    @(negedge clk) line_sym = 2'b10;
    @(posedge clk); #1;
    check("R3 invalid code", 32'(code_viol), 1);

    finish_run();
  end
endmodule